// File: doc/BRIEF.md
# Multichannel DAC Control Register Bank

This block holds the digital control state of a four-channel, 8-bit multiplying DAC used as a set of volume controls. A serial front end decodes each transfer into a 4-bit address and an 8-bit data byte. It then presents them to this bank as a single-cycle write strobe. The bank decodes a 16-entry address map. It drives, per channel, the code applied to the converter, a 2-bit reference select, a bypass flag and an output buffer enable.

Each channel has a code register and a hold latch. While hold is clear, the applied code tracks the code register. While hold is set, the applied code stays frozen and the code register keeps accepting writes. Several channels can therefore be loaded one at a time and then released together. Writing a key value to a dedicated address clears every register, the same way the hardware reset does. The analog transfer each channel realises is out = (vin − vref) × code / 256 + vref, with vref picked by the reference select.

Top module: `dac_ctrl_bank`

## Requirements
- R1: A write to address 0x0, 0x1, 0x2 or 0x3 loads the 8-bit code of channel 0, 1, 2 or 3. When that channel's hold bit is 0, the new code appears on its slice of `code_out` (bits 8i+7:8i) one clock after the strobe.
- R2: A write to address 0x8 sets the reference selects. Channel i takes data bits 2i+1:2i onto `ref_sel[2i+1:2i]`, one clock after the strobe. The encoding is 00 ground, 01 supply, 10 half supply and 11 external reference.
- R3: A write to address 0xA sets `bypass[i]` from data bit i, for i = 0 to 3. A 1 routes the half-supply level to output i in place of the converter.
- R4: A write to address 0xB sets `buf_en[i]` from data bit i. A 0 means the buffer is powered down with a high-impedance output, and a 1 means the buffer is active.
- R5: Writing 0xAA to address 0xC clears every register one clock later. This includes the code registers, the hold bits and the applied codes, so every output reads 0. After this, a code write reaches `code_out` with no hold in effect.
- R6: Writing any value other than 0xAA to address 0xC changes nothing.
- R7: A write to address 0xD sets hold bit i from data bit i. While hold bit i is 1, channel i's `code_out` slice stays at the value it had when the bit was set, even if its code register is written.
- R8: When hold bit i is cleared, channel i's `code_out` slice is unchanged on the clock after the strobe. It takes the current code register value on the clock after that.
- R9: Writes to addresses 0x4–0x7, 0x9, 0xE and 0xF change no output or state. Data bits 7:4 written to 0xA, 0xB or 0xD are ignored.
- R10: While `rst` is high at a rising clock edge, every register is cleared and all outputs read 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per transfer |
| wr_addr | input | 4 | Register address of the write |
| wr_data | input | 8 | Data byte of the write |
| code_out | output | 32 | Applied DAC codes, channel i in bits 8i+7:8i |
| ref_sel | output | 8 | Reference selects, channel i in bits 2i+1:2i |
| bypass | output | 4 | Per-channel half-supply bypass |
| buf_en | output | 4 | Per-channel output buffer enable |

## Verification
Every write takes effect at the rising edge that samples the strobe, so codes, reference selects, bypass and buffer flags are due one cycle after the strobe. The one exception is a hold release, where the applied code moves one cycle later still, two cycles after the strobe. The bench drives on falling edges and samples on the next falling edge after the capturing rising edge. For a hold release it samples twice: once to see the frozen value still present, and once a cycle later to see the register value.

// File: rtl/dacb_pkg.sv
package dacb_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int REF_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    AD_CODE0 = 4'h0,
    AD_CODE1 = 4'h1,
    AD_CODE2 = 4'h2,
    AD_CODE3 = 4'h3,
    AD_REFS  = 4'h8,
    AD_BYP   = 4'hA,
    AD_BUF   = 4'hB,
    AD_KEY   = 4'hC,
    AD_HOLD  = 4'hD
  } reg_addr_e;

  typedef enum logic [REF_W-1:0] {
    REF_GROUND = 2'b00,
    REF_SUPPLY = 2'b01,
    REF_HALF   = 2'b10,
    REF_EXTERN = 2'b11
  } ref_src_e;

  localparam logic [DATA_W-1:0] CLEAR_KEY = 8'hAA;

  typedef struct packed {
    logic refs_we;
    logic byp_we;
    logic buf_we;
    logic hold_we;
    logic clear;
  } ctl_strobe_t;

endpackage

// File: rtl/dacb_decode.sv
module dacb_decode
  import dacb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NCH-1:0]    code_we,
  output ctl_strobe_t       strobe
);

  // one code-register strobe per channel, at consecutive addresses from 0
  for (genvar g = 0; g < NCH; g++) begin : g_code_dec
    assign code_we[g] = wr_en && (wr_addr == ADDR_W'(g));
  end

  always_comb begin
    strobe         = '0;
    strobe.refs_we = wr_en && (wr_addr == AD_REFS);
    strobe.byp_we  = wr_en && (wr_addr == AD_BYP);
    strobe.buf_we  = wr_en && (wr_addr == AD_BUF);
    strobe.hold_we = wr_en && (wr_addr == AD_HOLD);
    // only the exact key value triggers the clear; any other byte is dropped
    strobe.clear   = wr_en && (wr_addr == AD_KEY) && (wr_data == CLEAR_KEY);
  end

endmodule

// File: rtl/dacb_ctrl_regs.sv
module dacb_ctrl_regs
  import dacb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  ctl_strobe_t        strobe,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NCH*REF_W-1:0] refs_q,
  output logic [NCH-1:0]     byp_q,
  output logic [NCH-1:0]     buf_q,
  output logic [NCH-1:0]     hold_q
);

  localparam int REFS_BITS = NCH * REF_W;

  always_ff @(posedge clk) begin
    if (rst || strobe.clear) begin
      refs_q <= '0;
      byp_q  <= '0;
      buf_q  <= '0;
      hold_q <= '0;
    end else begin
      if (strobe.refs_we) refs_q <= wr_data[REFS_BITS-1:0];
      // nibble registers: only one bit per channel is kept
      if (strobe.byp_we)  byp_q  <= wr_data[NCH-1:0];
      if (strobe.buf_we)  buf_q  <= wr_data[NCH-1:0];
      if (strobe.hold_we) hold_q <= wr_data[NCH-1:0];
    end
  end

endmodule

// File: rtl/dacb_channel.sv
module dacb_channel
  import dacb_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              code_we,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hold,
  output logic [DATA_W-1:0] code_q,
  output logic [DATA_W-1:0] applied_q
);

  logic [DATA_W-1:0] code_next;

  assign code_next = code_we ? wr_data : code_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      code_q    <= '0;
      applied_q <= '0;
    end else begin
      code_q <= code_next;
      // a released latch passes the value the register takes at this edge
      if (!hold) applied_q <= code_next;
    end
  end

endmodule

// File: rtl/dac_ctrl_bank.sv
module dac_ctrl_bank
  import dacb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [NCH*DATA_W-1:0] code_out,
  output logic [NCH*REF_W-1:0]  ref_sel,
  output logic [NCH-1:0]        bypass,
  output logic [NCH-1:0]        buf_en
);

  localparam int CODE_BITS = NCH * DATA_W;

  logic [NCH-1:0]       code_we;
  ctl_strobe_t          strobe;
  logic [NCH-1:0]       hold_q;
  logic [CODE_BITS-1:0] code_reg;

  dacb_decode #(.NCH(NCH)) u_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .code_we (code_we),
    .strobe  (strobe)
  );

  dacb_ctrl_regs #(.NCH(NCH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .wr_data (wr_data),
    .refs_q  (ref_sel),
    .byp_q   (bypass),
    .buf_q   (buf_en),
    .hold_q  (hold_q)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dacb_channel u_chan (
      .clk       (clk),
      .rst       (rst),
      .clear     (strobe.clear),
      .code_we   (code_we[g]),
      .wr_data   (wr_data),
      .hold      (hold_q[g]),
      .code_q    (code_reg[g*DATA_W +: DATA_W]),
      .applied_q (code_out[g*DATA_W +: DATA_W])
    );
  end

endmodule

// File: rtl/dacb_checker.sv
module dacb_checker
  import dacb_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [DATA_W-1:0]     wr_data,
  input logic [NCH*DATA_W-1:0] code_out,
  input logic [NCH*REF_W-1:0]  ref_sel,
  input logic [NCH-1:0]        bypass,
  input logic [NCH-1:0]        buf_en,
  input logic [NCH-1:0]        hold_q,
  input logic [NCH*DATA_W-1:0] code_reg
);

  logic key_wr, nokey_wr, dead_wr, rst_seen;

  assign key_wr   = wr_en && (wr_addr == 4'hC) && (wr_data == 8'hAA);
  assign nokey_wr = wr_en && (wr_addr == 4'hC) && (wr_data != 8'hAA);
  assign dead_wr  = wr_en && ((wr_addr >= ADDR_W'(NCH) && wr_addr <= 4'h7) ||
                              wr_addr == 4'h9 || wr_addr == 4'hE || wr_addr == 4'hF);

  always_ff @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen === 1'b1) begin
      AST_HW_RESET_CLEAR: assert (code_out == '0 && ref_sel == '0 && bypass == '0 && buf_en == '0 && hold_q == '0) else $error("reset clear"); // R10
    end
  end

  AST_REFS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 4'h8) |=> ref_sel == $past(wr_data[NCH*REF_W-1:0])) else $error("refs"); // R2

  AST_BYP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 4'hA) |=> bypass == $past(wr_data[NCH-1:0])) else $error("bypass"); // R3

  AST_BUF_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 4'hB) |=> buf_en == $past(wr_data[NCH-1:0])) else $error("buf"); // R4

  AST_KEY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    key_wr |=> (code_out == '0 && ref_sel == '0 && bypass == '0 && buf_en == '0 && hold_q == '0)) else $error("key clear"); // R5

  AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    nokey_wr |=> ($stable(ref_sel) && $stable(bypass) && $stable(buf_en) && $stable(hold_q) && $stable(code_reg))) else $error("bad key"); // R6

  AST_DEAD_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    dead_wr |=> ($stable(ref_sel) && $stable(bypass) && $stable(buf_en) && $stable(hold_q) && $stable(code_reg))) else $error("dead addr"); // R9

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_CODE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_W'(g) && !hold_q[g]) |=> code_out[g*DATA_W +: DATA_W] == $past(wr_data)) else $error("code follow"); // R1

    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
      (hold_q[g] && !key_wr) |=> $stable(code_out[g*DATA_W +: DATA_W])) else $error("hold freeze"); // R7

    AST_RELEASE_CATCHUP: assert property (@(posedge clk) disable iff (rst)
      ($fell(hold_q[g]) && !wr_en) |=> code_out[g*DATA_W +: DATA_W] == $past(code_reg[g*DATA_W +: DATA_W])) else $error("release"); // R8
  end

endmodule

bind dac_ctrl_bank dacb_checker #(.NCH(NCH)) u_dacb_checker (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .code_out (code_out),
  .ref_sel  (ref_sel),
  .bypass   (bypass),
  .buf_en   (buf_en),
  .hold_q   (hold_q),
  .code_reg (code_reg)
);

// File: tb/test_dac_ctrl_bank.sv
module test_dac_ctrl_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [31:0] code_out;
  logic [7:0]  ref_sel;
  logic [3:0]  bypass;
  logic [3:0]  buf_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_ctrl_bank i_dac_ctrl_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .code_out(code_out), .ref_sel(ref_sel), .bypass(bypass), .buf_en(buf_en)
  );

  // {req, addr, data, group(0 code,1 ref,2 bypass,3 buf), expected}
  localparam logic [49:0] VEC [NVEC] = '{
    {4'd1,  4'h0, 8'h12, 2'd0, 32'h0000_0012},  // R1 channel 0
    {4'd1,  4'h1, 8'h34, 2'd0, 32'h0000_3412},  // R1 channel 1
    {4'd1,  4'h2, 8'hFF, 2'd0, 32'h00FF_3412},  // R1 channel 2
    {4'd1,  4'h3, 8'h80, 2'd0, 32'h80FF_3412},  // R1 channel 3
    {4'd2,  4'h8, 8'hE4, 2'd1, 32'h0000_00E4},  // R2 ch3 ext, ch2 half, ch1 supply, ch0 ground
    {4'd3,  4'hA, 8'hF5, 2'd2, 32'h0000_0005},  // R3 upper nibble dropped
    {4'd4,  4'hB, 8'hAC, 2'd3, 32'h0000_000C},  // R4 upper nibble dropped
    {4'd9,  4'h4, 8'hFF, 2'd0, 32'h80FF_3412},  // R9 unused address
    {4'd9,  4'h9, 8'h00, 2'd1, 32'h0000_00E4},  // R9 unused address
    {4'd9,  4'hE, 8'h55, 2'd2, 32'h0000_0005},  // R9 unused address
    {4'd9,  4'hF, 8'h11, 2'd3, 32'h0000_000C},  // R9 unused address
    {4'd6,  4'hC, 8'hAB, 2'd1, 32'h0000_00E4},  // R6 wrong key
    {4'd1,  4'h0, 8'h00, 2'd0, 32'h80FF_3400}   // R1 zero code
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] grp(input logic [1:0] s);
    case (s)
      2'd0:    return code_out;
      2'd1:    return {24'h0, ref_sel};
      2'd2:    return {28'h0, bypass};
      default: return {28'h0, buf_en};
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 code", code_out, 32'h0);
    chk("R10 ref", {24'h0, ref_sel}, 32'h0);
    chk("R10 bypass", {28'h0, bypass}, 32'h0);
    chk("R10 buf", {28'h0, buf_en}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][45:42], VEC[i][41:34]);
      chk($sformatf("R%0d vec%0d", VEC[i][49:46], i), grp(VEC[i][33:32]), VEC[i][31:0]);
    end

    // R7: hold channel 0, write it and channel 1
    wr(4'hD, 8'h01);
    wr(4'h0, 8'h77);
    chk("R7 frozen ch0", code_out, 32'h80FF_3400);
    wr(4'h1, 8'h11);
    chk("R7 other channel free", code_out, 32'h80FF_1100);
    // R8 release (upper bits of hold write ignored, R9)
    wr(4'hD, 8'hF0);
    chk("R8 still frozen", code_out, 32'h80FF_1100);
    @(negedge clk);
    chk("R8 caught up", code_out, 32'h80FF_1177);

    // R4 buffer off, R3 bypass pattern
    wr(4'hB, 8'h00);
    chk("R4 buffers down", {28'h0, buf_en}, 32'h0);
    wr(4'hA, 8'h0A);
    chk("R3 bypass", {28'h0, bypass}, 32'hA);

    // R5 key clear with hold active
    wr(4'hD, 8'h02);
    wr(4'hC, 8'hAA);
    chk("R5 code", code_out, 32'h0);
    chk("R5 ref", {24'h0, ref_sel}, 32'h0);
    chk("R5 bypass", {28'h0, bypass}, 32'h0);
    wr(4'h1, 8'h99);
    chk("R5 hold cleared", code_out, 32'h0000_9900);

    // R10 reset mid-run
    wr(4'h8, 8'h1B);
    wr(4'hB, 8'h0F);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 code", code_out, 32'h0);
    chk("R10 ref", {24'h0, ref_sel}, 32'h0);
    chk("R10 buf", {28'h0, buf_en}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule